// File: doc/BRIEF.md
# Control Endpoint Data-Phase Sequencer

This block runs the data and status stages of a control transfer on the default endpoint for an external master. A setup packet arrives as a byte stream. The block keeps the requested transfer length, taken from setup bytes 6 (low) and 7 (high), for the whole transfer. It loads the eight setup bytes into its packet buffer and raises a setup interrupt. The master then reads the setup bytes through the same two registers it uses for data: a byte-count register and a data register.

Data moves in packets of at most 64 bytes. For host-bound (IN) transfers, the master fills the buffer and arms a packet by writing the desired count. The block clamps that count to both the packet limit and the bytes still owed. It streams the packet out on the next IN token. For device-bound (OUT) transfers, the block accepts packets only while the buffer has been fully read. The handshake completes without master help on a short IN packet, a zero-length IN packet, or once the owed length reaches zero.

The master can stall the transfer. A stall is held until the next setup packet arrives. A new setup packet always aborts the current transfer and restarts the sequence.

Top module: `ep0_dphase_seq`

## Requirements
- R1: After reset, no output pulse, stream or stall is active, `out_ready` is low and the count register (address 0x33) reads 0.
- R2: An 8-byte setup packet raises `irq_setup` for one cycle in the cycle after its final byte. The count register then reads 8, and successive reads of the data register (address 0x31) return the setup bytes in arrival order. The requested length is byte 6 plus 256 times byte 7. Bit 7 of byte 0 set selects the IN direction.
- R3: In an OUT data stage, `out_ready` is high only while every buffered byte has been read. Each received OUT packet sets the count register to its length, returns its bytes in order through the data register, and pulses `irq_buf`.
- R4: When the OUT bytes received total the requested length, `hs_done` pulses and the block stops accepting OUT data.
- R5: In an IN stage, writing N to the count register arms a packet. The next `in_token` then streams the armed bytes in write order on consecutive cycles, with `tx_last` on the final byte.
- R6: The armed IN count is the smallest of the written value, 64 and the bytes still owed. Bytes written beyond it are never sent.
- R7: An IN packet shorter than 64 bytes ends the transfer with an `hs_done` pulse. A full 64-byte packet that leaves bytes owed pulses `irq_buf` and does not end the transfer.
- R8: Writing 0 to the count register in an IN stage arms a zero-length packet. The next token produces a one-cycle `tx_zlp` with no data and ends the transfer.
- R9: An IN transfer whose sent total reaches the requested length ends with `hs_done`, even when the last packet is full size.
- R10: After a setup with requested length 0, a write of 0 to the count register pulses `hs_done` and sends nothing.
- R11: A setup packet that arrives mid-transfer raises `irq_setup` again, discards any armed IN packet and starts the new transfer.
- R12: Writing 1 to bit 0 of the control register (address 0x34) sets `stall_o`. While stalled, `out_ready` is low and IN tokens send nothing. A write of 0 leaves the stall in place, and the next setup packet clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the received packet |
| rx_setup | input | 1 | Received packet is a setup packet |
| out_ready | output | 1 | Buffer free for an OUT data packet |
| in_token | input | 1 | Host asks for an IN packet |
| tx_valid | output | 1 | Transmitted byte valid |
| tx_data | output | 8 | Transmitted byte |
| tx_last | output | 1 | Final transmitted byte of the packet |
| tx_zlp | output | 1 | Zero-length IN packet sent |
| reg_wr | input | 1 | Master register write strobe |
| reg_rd | input | 1 | Master register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_setup | output | 1 | Setup packet received, one-cycle pulse |
| irq_buf | output | 1 | Buffer ready for the master, one-cycle pulse |
| hs_done | output | 1 | Handshake stage completed, one-cycle pulse |
| stall_o | output | 1 | Transfer stalled |

## Verification
The bench targets the IN count clamp twice: once against a remainder smaller than the armed count, and once with an over-large count at exactly 64 owed bytes. A design that skipped the clamp would stream extra bytes, and the byte-by-byte stream check would flag them. A full packet that still leaves bytes owed must raise `irq_buf` and not `hs_done`. The bench then finishes that transfer with a zero-length packet, which catches a design that ends on every full packet or never sends an empty one. It also aborts an armed IN packet with a new setup and tries to lift a stall with a zero write. A leaked packet or a cleared stall shows up on the ports.

// File: rtl/ep0_seq_pkg.sv
`timescale 1ns/1ps
package ep0_seq_pkg;
    localparam int PKT_MAX = 64;
    localparam int LEN_W   = 16;

    localparam logic [7:0] REG_DATA  = 8'h31;
    localparam logic [7:0] REG_COUNT = 8'h33;
    localparam logic [7:0] REG_CTRL  = 8'h34;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_NODATA,
        PH_IN,
        PH_OUT,
        PH_HALT
    } phase_e;

    typedef struct packed {
        logic             dir_in;
        logic [LEN_W-1:0] wlen;
    } setup_info_t;

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/ep0_setup_capture.sv
`timescale 1ns/1ps
module ep0_setup_capture
    import ep0_seq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_setup,
    input  logic             rx_last,
    input  logic [7:0]       rx_data,
    output logic             cap_we,
    output logic [IDX_W-1:0] cap_idx,
    output logic             setup_done,
    output setup_info_t      info
);
    localparam int SETUP_BYTES = 8;
    localparam logic [3:0] LAST_IDX = 4'(SETUP_BYTES - 1);

    logic [3:0] sidx;
    logic       take;

    assign take    = rx_valid && rx_setup;
    assign cap_we  = take && (sidx < 4'(SETUP_BYTES));
    assign cap_idx = IDX_W'(sidx[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sidx       <= '0;
            setup_done <= 1'b0;
            info       <= '0;
        end else begin
            setup_done <= take && rx_last && (sidx == LAST_IDX);
            if (take) begin
                case (sidx)
                    4'd0: info.dir_in        <= rx_data[7];
                    4'd6: info.wlen[7:0]     <= rx_data;
                    4'd7: info.wlen[15:8]    <= rx_data;
                    default: ;
                endcase
                if (rx_last)
                    sidx <= '0;
                else if (sidx < 4'(SETUP_BYTES))
                    sidx <= sidx + 4'd1;
            end
        end
    end

    AST_SETUP_PULSE: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> !setup_done); // R2
endmodule

// File: rtl/ep0_pkt_buf.sv
`timescale 1ns/1ps
module ep0_pkt_buf #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [7:0]       rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [7:0]       rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/ep0_in_tx.sv
`timescale 1ns/1ps
module ep0_in_tx #(
    parameter int PKT_MAX = 64,
    parameter int CNT_W   = $clog2(PKT_MAX + 1),
    parameter int IDX_W   = $clog2(PKT_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             tx_zlp
);
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] len_q;
    logic             at_end;

    assign at_end   = (len_q == '0) || (idx == len_q - 1'b1);
    assign tx_valid = busy && (len_q != '0);
    assign tx_zlp   = busy && (len_q == '0);
    assign tx_last  = tx_valid && (idx == len_q - 1'b1);
    assign tx_data  = rd_data;
    assign rd_idx   = idx[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    idx   <= '0;
                    len_q <= len;
                end
            end else if (at_end) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_TX_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last && !abort) |=> tx_valid); // R5
endmodule

// File: rtl/ep0_dphase_seq.sv
`timescale 1ns/1ps
module ep0_dphase_seq
    import ep0_seq_pkg::*;
#(
    parameter int PKT_BYTES = ep0_seq_pkg::PKT_MAX,
    parameter int LEN_BITS  = ep0_seq_pkg::LEN_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    input  logic       rx_setup,
    output logic       out_ready,
    input  logic       in_token,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_last,
    output logic       tx_zlp,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_setup,
    output logic       irq_buf,
    output logic       hs_done,
    output logic       stall_o
);
    localparam int CNT_W = $clog2(PKT_BYTES + 1);
    localparam int IDX_W = $clog2(PKT_BYTES);
    localparam logic [CNT_W-1:0]    MAXC       = CNT_W'(PKT_BYTES);
    localparam logic [LEN_BITS-1:0] MAXL       = LEN_BITS'(PKT_BYTES);
    localparam logic [CNT_W-1:0]    SETUP_CNT  = CNT_W'(8);

    phase_e               phase;
    logic [LEN_BITS-1:0]  remaining;
    logic [CNT_W-1:0]     cnt, rd_ptr, in_wptr, out_wptr, arm_len, arm_calc, got;
    logic                 rx_active, armed, stall_q, hs_q, irqb_q;

    logic                 cap_we, setup_done;
    logic [IDX_W-1:0]     cap_idx;
    setup_info_t          info;

    logic                 tx_busy, tx_done, tx_start, tx_abort;
    logic [IDX_W-1:0]     tx_idx;
    logic [7:0]           buf_rd_a, buf_rd_b;

    logic                 buf_we;
    logic [IDX_W-1:0]     buf_waddr;
    logic [7:0]           buf_wdata;

    logic buf_drained, out_accept, out_store, in_fill, arm_wr, nodata_wr, stall_wr, rd_pop;
    logic [LEN_BITS-1:0]  req_lim;

    // ---------------- decode ----------------
    assign buf_drained = (rd_ptr == cnt);
    assign out_ready   = (phase == PH_OUT) && buf_drained && !rx_active;
    assign out_accept  = (phase == PH_OUT) && rx_valid && !rx_setup && (rx_active || buf_drained);
    assign out_store   = out_accept && (out_wptr < MAXC);
    assign in_fill     = (phase == PH_IN) && !armed && !tx_busy && reg_wr
                         && (reg_addr == REG_DATA) && (in_wptr < MAXC);
    assign arm_wr      = (phase == PH_IN) && !armed && !tx_busy && reg_wr && (reg_addr == REG_COUNT);
    assign nodata_wr   = (phase == PH_NODATA) && reg_wr && (reg_addr == REG_COUNT);
    assign stall_wr    = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0];
    assign rd_pop      = reg_rd && (reg_addr == REG_DATA) && !buf_drained;
    assign tx_start    = in_token && armed && (phase == PH_IN) && !tx_busy;
    assign tx_abort    = setup_done || stall_wr;

    assign req_lim  = min_len(LEN_BITS'(reg_wdata), MAXL);
    assign arm_calc = CNT_W'(min_len(req_lim, remaining));
    assign got      = out_wptr + ((out_wptr < MAXC) ? CNT_W'(1) : CNT_W'(0));

    // buffer write port: setup bytes win, then OUT data, then master fill
    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = '0;
        if (cap_we) begin
            buf_we    = 1'b1;
            buf_waddr = cap_idx;
            buf_wdata = rx_data;
        end else if (out_store) begin
            buf_we    = 1'b1;
            buf_waddr = out_wptr[IDX_W-1:0];
            buf_wdata = rx_data;
        end else if (in_fill) begin
            buf_we    = 1'b1;
            buf_waddr = in_wptr[IDX_W-1:0];
            buf_wdata = reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_DATA:  reg_rdata = buf_drained ? 8'h00 : buf_rd_a;
            REG_COUNT: reg_rdata = 8'(cnt);
            REG_CTRL:  reg_rdata = {7'b0, stall_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

    // ---------------- sub-blocks ----------------
    ep0_setup_capture #(.IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_setup(rx_setup),
        .rx_last(rx_last), .rx_data(rx_data), .cap_we(cap_we), .cap_idx(cap_idx),
        .setup_done(setup_done), .info(info)
    );

    ep0_pkt_buf #(.DEPTH(PKT_BYTES), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr_a(rd_ptr[IDX_W-1:0]), .rdata_a(buf_rd_a),
        .raddr_b(tx_idx), .rdata_b(buf_rd_b)
    );

    ep0_in_tx #(.PKT_MAX(PKT_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst(rst), .abort(tx_abort), .start(tx_start), .len(arm_len),
        .rd_idx(tx_idx), .rd_data(buf_rd_b), .busy(tx_busy), .done(tx_done),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp)
    );

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            remaining <= '0;
            cnt       <= '0;
            rd_ptr    <= '0;
            in_wptr   <= '0;
            out_wptr  <= '0;
            arm_len   <= '0;
            rx_active <= 1'b0;
            armed     <= 1'b0;
            stall_q   <= 1'b0;
            hs_q      <= 1'b0;
            irqb_q    <= 1'b0;
        end else begin
            hs_q   <= 1'b0;
            irqb_q <= 1'b0;
            if (setup_done) begin
                cnt       <= SETUP_CNT;
                rd_ptr    <= '0;
                in_wptr   <= '0;
                out_wptr  <= '0;
                rx_active <= 1'b0;
                armed     <= 1'b0;
                stall_q   <= 1'b0;
                remaining <= info.wlen;
                if (info.wlen == '0)
                    phase <= PH_NODATA;
                else if (info.dir_in)
                    phase <= PH_IN;
                else
                    phase <= PH_OUT;
            end else begin
                if (rd_pop)
                    rd_ptr <= rd_ptr + 1'b1;
                if (stall_wr) begin
                    stall_q   <= 1'b1;
                    phase     <= PH_HALT;
                    armed     <= 1'b0;
                    rx_active <= 1'b0;
                end else begin
                    case (phase)
                        PH_NODATA: begin
                            if (nodata_wr) begin
                                hs_q  <= 1'b1;
                                phase <= PH_IDLE;
                            end
                        end
                        PH_IN: begin
                            if (in_fill)
                                in_wptr <= in_wptr + 1'b1;
                            if (arm_wr) begin
                                armed   <= 1'b1;
                                arm_len <= arm_calc;
                            end
                            if (tx_done) begin
                                armed     <= 1'b0;
                                in_wptr   <= '0;
                                remaining <= remaining - LEN_BITS'(arm_len);
                                if ((arm_len != MAXC) || (remaining == LEN_BITS'(arm_len))) begin
                                    hs_q  <= 1'b1;
                                    phase <= PH_IDLE;
                                end else begin
                                    irqb_q <= 1'b1;
                                end
                            end
                        end
                        PH_OUT: begin
                            if (out_accept) begin
                                if (out_store)
                                    out_wptr <= out_wptr + 1'b1;
                                if (rx_last) begin
                                    rx_active <= 1'b0;
                                    out_wptr  <= '0;
                                    cnt       <= got;
                                    rd_ptr    <= '0;
                                    irqb_q    <= 1'b1;
                                    if (LEN_BITS'(got) >= remaining) begin
                                        remaining <= '0;
                                        hs_q      <= 1'b1;
                                        phase     <= PH_IDLE;
                                    end else begin
                                        remaining <= remaining - LEN_BITS'(got);
                                    end
                                end else begin
                                    rx_active <= 1'b1;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign irq_setup = setup_done;
    assign irq_buf   = irqb_q;
    assign hs_done   = hs_q;
    assign stall_o   = stall_q;

    // ---------------- assertions ----------------
    AST_ARM_CLAMP: assert property (@(posedge clk) disable iff (rst)
        armed |-> (LEN_BITS'(arm_len) <= remaining) && (arm_len <= MAXC)); // R6
    AST_REMAIN_NONINC: assert property (@(posedge clk) disable iff (rst)
        !setup_done |=> (remaining <= $past(remaining))); // R6
    AST_HS_STOPS_OUT: assert property (@(posedge clk) disable iff (rst)
        hs_done |-> !out_ready); // R4
    AST_STALL_NO_TX: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (!tx_valid && !tx_zlp && !out_ready)); // R12
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !irq_setup) |=> stall_o); // R12
    AST_SETUP_CLEARS_STALL: assert property (@(posedge clk) disable iff (rst)
        irq_setup |=> !stall_o); // R12
endmodule

// File: tb/ep0_dphase_seq_tb.sv
`timescale 1ns/1ps
module ep0_dphase_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 0, rx_last = 0, rx_setup = 0;
    logic [7:0] rx_data = 0;
    logic       in_token = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic       out_ready, tx_valid, tx_last, tx_zlp;
    logic [7:0] tx_data, reg_rdata;
    logic       irq_setup, irq_buf, hs_done, stall_o;

    int checks = 0, failures = 0;
    int hs_n = 0, setup_n = 0, bufi_n = 0, zlp_n = 0, tx_n = 0;
    int cycles = 0;
    bit m_stall = 0;
    bit finished = 0;
    int exp_q[$];
    logic [7:0] setup_bytes [8];

    always #2 clk = ~clk;

    ep0_dphase_seq dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_setup(rx_setup), .out_ready(out_ready), .in_token(in_token),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_setup(irq_setup), .irq_buf(irq_buf),
        .hs_done(hs_done), .stall_o(stall_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-clock reference comparison: IN byte stream and stall level
    always @(negedge clk) begin
        if (!rst) begin
            if (hs_done)   hs_n++;
            if (irq_setup) setup_n++;
            if (irq_buf)   bufi_n++;
            if (tx_zlp)    zlp_n++;
            if (tx_valid) begin
                tx_n++;
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected IN byte", int'(tx_data), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'({tx_last, tx_data}) == e, "R5", "IN byte/last", int'({tx_last, tx_data}), e);
                end
            end
            check(stall_o == m_stall, "R12", "stall level", int'(stall_o), int'(m_stall));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1; reg_addr = a;
        #0.5;
        d = reg_rdata;
        tick();
        reg_rd = 0;
    endtask

    task automatic do_setup(input logic [7:0] b0, input logic [15:0] wl);
        setup_bytes[0] = b0;    setup_bytes[1] = 8'h06;
        setup_bytes[2] = 8'h11; setup_bytes[3] = 8'h22;
        setup_bytes[4] = 8'h33; setup_bytes[5] = 8'h44;
        setup_bytes[6] = wl[7:0]; setup_bytes[7] = wl[15:8];
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1; rx_setup = 1; rx_data = setup_bytes[i]; rx_last = (i == 7);
            tick();
        end
        rx_valid = 0; rx_setup = 0; rx_last = 0;
        tick();
        m_stall = 0;
    endtask

    task automatic read_setup();
        logic [7:0] d;
        reg_read(8'h33, d);
        check(d == 8, "R2", "setup count", d, 8);
        for (int i = 0; i < 8; i++) begin
            reg_read(8'h31, d);
            check(d == setup_bytes[i], "R2", "setup byte", d, setup_bytes[i]);
        end
    endtask

    task automatic send_out(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_setup = 0; rx_data = base + 8'(i); rx_last = (i == n - 1);
            tick();
        end
        rx_valid = 0; rx_last = 0;
        tick();
    endtask

    task automatic read_out(input int n, input logic [7:0] base);
        logic [7:0] d;
        reg_read(8'h33, d);
        check(d == 8'(n), "R3", "OUT count", d, n);
        for (int i = 0; i < n; i++) begin
            reg_read(8'h31, d);
            check(d == base + 8'(i), "R3", "OUT byte", d, int'(base + 8'(i)));
        end
    endtask

    task automatic fill_in(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) reg_write(8'h31, base + 8'(i));
    endtask

    task automatic expect_in(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) exp_q.push_back(int'({(i == n - 1), base + 8'(i)}));
    endtask

    task automatic token(input int wait_cycles);
        in_token = 1;
        tick();
        in_token = 0;
        repeat (wait_cycles) tick();
    endtask

    initial begin
        int h0, b0, z0, t0, s0;
        logic [7:0] d;
        repeat (4) tick();
        rst = 0;
        tick();

        // R1 reset state
        check(stall_o == 0 && out_ready == 0 && tx_valid == 0 && hs_done == 0, "R1", "idle outputs",
              int'({stall_o, out_ready, tx_valid, hs_done}), 0);
        reg_read(8'h33, d);
        check(d == 0, "R1", "count after reset", d, 0);

        // OUT transfer of 100 bytes
        s0 = setup_n;
        do_setup(8'h00, 16'd100);
        check(setup_n == s0 + 1, "R2", "irq_setup pulses", setup_n - s0, 1);
        check(out_ready == 0, "R3", "ready before setup read", out_ready, 0);
        read_setup();
        check(out_ready == 1, "R3", "ready after drain", out_ready, 1);
        h0 = hs_n; b0 = bufi_n;
        send_out(64, 8'h40);
        check(bufi_n == b0 + 1, "R3", "irq_buf on packet", bufi_n - b0, 1);
        check(hs_n == h0, "R4", "no handshake midway", hs_n - h0, 0);
        check(out_ready == 0, "R3", "ready with unread data", out_ready, 0);
        read_out(64, 8'h40);
        check(out_ready == 1, "R3", "ready after packet read", out_ready, 1);
        send_out(36, 8'h90);
        check(hs_n == h0 + 1, "R4", "handshake at length", hs_n - h0, 1);
        read_out(36, 8'h90);
        check(out_ready == 0, "R4", "OUT closed", out_ready, 0);

        // IN transfer of 80 bytes: full packet then clamped remainder
        do_setup(8'h80, 16'd80);
        read_setup();
        h0 = hs_n; b0 = bufi_n;
        fill_in(64, 8'h00);
        reg_write(8'h33, 8'd64);
        expect_in(64, 8'h00);
        token(70);
        check(exp_q.size() == 0, "R5", "full packet sent", exp_q.size(), 0);
        check(bufi_n == b0 + 1, "R7", "irq_buf after full packet", bufi_n - b0, 1);
        check(hs_n == h0, "R7", "no handshake after full packet", hs_n - h0, 0);
        fill_in(20, 8'hC0);
        reg_write(8'h33, 8'd30);
        expect_in(16, 8'hC0);
        token(24);
        check(exp_q.size() == 0, "R6", "clamped to owed bytes", exp_q.size(), 0);
        check(hs_n == h0 + 1, "R9", "handshake at length", hs_n - h0, 1);

        // short IN packet
        do_setup(8'h80, 16'd300);
        read_setup();
        h0 = hs_n;
        fill_in(10, 8'h20);
        reg_write(8'h33, 8'd10);
        expect_in(10, 8'h20);
        token(16);
        check(exp_q.size() == 0, "R5", "short packet sent", exp_q.size(), 0);
        check(hs_n == h0 + 1, "R7", "handshake on short packet", hs_n - h0, 1);

        // exact 64 with oversize count
        do_setup(8'h80, 16'd64);
        read_setup();
        h0 = hs_n;
        fill_in(64, 8'h70);
        reg_write(8'h33, 8'd200);
        expect_in(64, 8'h70);
        token(70);
        check(exp_q.size() == 0, "R6", "count clamped to 64", exp_q.size(), 0);
        check(hs_n == h0 + 1, "R9", "handshake at exact length", hs_n - h0, 1);

        // full packet then zero-length packet
        do_setup(8'h80, 16'd128);
        read_setup();
        h0 = hs_n; z0 = zlp_n;
        fill_in(64, 8'h01);
        reg_write(8'h33, 8'd64);
        expect_in(64, 8'h01);
        token(70);
        check(hs_n == h0, "R7", "open after full packet", hs_n - h0, 0);
        t0 = tx_n;
        reg_write(8'h33, 8'd0);
        token(6);
        check(zlp_n == z0 + 1, "R8", "zero-length packet", zlp_n - z0, 1);
        check(tx_n == t0, "R8", "no bytes in zlp", tx_n - t0, 0);
        check(hs_n == h0 + 1, "R8", "handshake after zlp", hs_n - h0, 1);

        // no data stage
        do_setup(8'h00, 16'd0);
        read_setup();
        h0 = hs_n; z0 = zlp_n; t0 = tx_n;
        reg_write(8'h33, 8'd0);
        tick(); tick();
        check(hs_n == h0 + 1, "R10", "no-data handshake", hs_n - h0, 1);
        check(zlp_n == z0 && tx_n == t0, "R10", "nothing sent", (zlp_n - z0) + (tx_n - t0), 0);

        // abort armed IN with a new setup
        do_setup(8'h80, 16'd100);
        read_setup();
        fill_in(5, 8'h55);
        reg_write(8'h33, 8'd5);
        s0 = setup_n; t0 = tx_n; z0 = zlp_n;
        do_setup(8'h00, 16'd10);
        check(setup_n == s0 + 1, "R11", "irq_setup again", setup_n - s0, 1);
        token(8);
        check(tx_n == t0 && zlp_n == z0, "R11", "armed packet discarded", tx_n - t0, 0);
        read_setup();
        check(out_ready == 1, "R11", "new OUT stage", out_ready, 1);
        h0 = hs_n;
        send_out(10, 8'hA0);
        check(hs_n == h0 + 1, "R11", "new transfer completes", hs_n - h0, 1);
        read_out(10, 8'hA0);

        // stall
        do_setup(8'h00, 16'd50);
        read_setup();
        reg_write(8'h34, 8'h01);
        m_stall = 1;
        tick();
        check(stall_o == 1 && out_ready == 0, "R12", "stalled, not ready",
              int'({stall_o, out_ready}), 2);
        t0 = tx_n;
        token(6);
        check(tx_n == t0, "R12", "token ignored in stall", tx_n - t0, 0);
        reg_write(8'h34, 8'h00);
        tick();
        check(stall_o == 1, "R12", "zero write keeps stall", stall_o, 1);
        do_setup(8'h00, 16'd50);
        tick();
        check(stall_o == 0, "R12", "setup clears stall", stall_o, 0);

        repeat (4) tick();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule